// File: doc/BRIEF.md
# Word-Granular Ownership Registry Bank

This block sits at one bank of a shared cache and keeps, for every word it holds, either the current data value or the identity of the private cache that owns that word. A single registered bit per word decides which of the two the storage slot holds. Private caches send it three kinds of request: a read, a registration (a claim of ownership of a word), and a writeback (an owner returning the word's value). Requests are taken one per cycle and handled strictly in the order they arrive. Each accepted request produces exactly one response on the following cycle.

When a word is owned, the bank does not answer reads or registrations from its own storage. It forwards them to the current owner, naming the original requester, and a registration also moves ownership to the new requester at once. No sharer list is held and no invalidations are ever sent. Each line also has a valid flag and a dirty flag. A writeback from the owner stores the value, releases the word and marks its line valid and dirty. Fetching data from memory, routing and replacement are left to the surrounding logic.

Top module: `ownr_registry_bank`

## Requirements
- R1: After reset no response is issued, every word is unowned and every line is invalid and clean, so a read of any word answers MISS.
- R2: A request with op code 0 (read), 1 (register) or 2 (writeback) gives exactly one response, with rsp_valid high on the cycle after the request. Op code 3 and idle cycles give no response. rsp_req always carries the requesting cache's ID.
- R3: A read of an unowned word in a valid line answers DATA (kind 0) to the requester. It carries the stored value on rsp_data and the line's dirty flag on rsp_dirty.
- R4: A read of an unowned word in an invalid line answers MISS (kind 4) to the requester.
- R5: A read of an owned word answers FWD_READ (kind 2), with rsp_dst set to the owner. It changes no state.
- R6: A registration of an unowned word answers ACK (kind 1) to the requester and carries the word's stored value. The requester becomes the owner.
- R7: A registration of a word owned by a different cache answers FWD_REG (kind 3), with rsp_dst set to the previous owner. Ownership passes to the requester.
- R8: A registration by the cache that already owns the word answers ACK, and ownership does not change.
- R9: A writeback (kind 5, WB_DONE) from the current owner stores rsp-visible data, releases the word and marks its line valid and dirty.
- R10: A writeback from a cache that is not the owner, or to an unowned word, answers WB_STALE (kind 6). It changes neither the data nor the ownership.
- R11: A request to a word in the cycle right after another request to the same word sees the state that the earlier request left.
- R12: Ownership is held per word, so registering one word leaves the other words of its line unowned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_op | input | 2 | 0 read, 1 register, 2 writeback, 3 reserved |
| req_src | input | ID_W | ID of the requesting private cache |
| req_line | input | LINE_W | Line index within the bank |
| req_word | input | WORD_W | Word index within the line |
| req_data | input | DATA_W | Writeback value |
| rsp_valid | output | 1 | A response is presented |
| rsp_kind | output | 3 | Response kind code (see requirements) |
| rsp_dst | output | ID_W | Cache the response goes to |
| rsp_req | output | ID_W | Cache that issued the request |
| rsp_data | output | DATA_W | Word value for DATA and ACK, else zero |
| rsp_dirty | output | 1 | Line dirty flag on DATA, else zero |

## Verification
Directed scenarios drive first claims, ownership steals, repeated claims by the owner, stale and genuine writebacks, and back-to-back requests to one word. They also drive reads placed before and after each of these. The reads are what separate the cases: FWD_READ to a named owner shows who holds a word, DATA shows that a writeback really landed, and MISS shows that a neighbouring word or an unwritten line stayed untouched. The back-to-back pairs tell whether the second request is decided on the state left by the first or on stale state.

// File: rtl/ownr_pkg.sv
package ownr_pkg;
  typedef enum logic [1:0] {
    OP_READ = 2'd0,
    OP_CLAIM = 2'd1,
    OP_WBACK = 2'd2,
    OP_RSVD = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    RK_DATA = 3'd0,
    RK_ACK = 3'd1,
    RK_FWD_READ = 3'd2,
    RK_FWD_CLAIM = 3'd3,
    RK_MISS = 3'd4,
    RK_WB_DONE = 3'd5,
    RK_WB_STALE = 3'd6
  } rsp_e;
endpackage

// File: rtl/ownr_word_store.sv
module ownr_word_store #(
  parameter int DEPTH = 64,
  parameter int DATA_W = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  // Distributed RAM: read is asynchronous so the next cycle sees the write.
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/ownr_meta.sv
module ownr_meta #(
  parameter int LINES = 16,
  parameter int WPL = 4,
  localparam int NW = LINES * WPL,
  localparam int AW = $clog2(NW),
  localparam int LINE_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     widx,
  input  logic [LINE_W-1:0] lidx,
  input  logic              own_set,
  input  logic              own_clr,
  input  logic              line_mark,
  output logic              owned,
  output logic              lvalid,
  output logic              ldirty
);
  logic [NW-1:0]    own_q;
  logic [LINES-1:0] val_q;
  logic [LINES-1:0] dty_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      own_q <= '0;
      val_q <= '0;
      dty_q <= '0;
    end else begin
      if (own_set) own_q[widx] <= 1'b1;
      else if (own_clr) own_q[widx] <= 1'b0;
      if (line_mark) begin
        val_q[lidx] <= 1'b1;
        dty_q[lidx] <= 1'b1;
      end
    end
  end

  assign owned  = own_q[widx];
  assign lvalid = val_q[lidx];
  assign ldirty = dty_q[lidx];

  // R9 / R10: a word is never claimed and released in the same cycle
  p_set_clr_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(own_set && own_clr));
endmodule

// File: rtl/ownr_decide.sv
module ownr_decide
  import ownr_pkg::*;
#(
  parameter int ID_W = 2,
  parameter int DATA_W = 32
) (
  input  logic              req_valid,
  input  op_e               op,
  input  logic [ID_W-1:0]   src,
  input  logic [DATA_W-1:0] wb_data,
  input  logic              owned,
  input  logic              lvalid,
  input  logic              ldirty,
  input  logic [DATA_W-1:0] stored,
  output logic              rsp_go,
  output rsp_e              kind,
  output logic [ID_W-1:0]   dst,
  output logic [DATA_W-1:0] data,
  output logic              dirty,
  output logic              store_we,
  output logic [DATA_W-1:0] store_wdata,
  output logic              own_set,
  output logic              own_clr,
  output logic              line_mark
);
  logic [ID_W-1:0] owner;
  logic            by_owner;

  assign owner    = stored[ID_W-1:0];
  assign by_owner = owned && (owner == src);

  always_comb begin
    rsp_go      = 1'b0;
    kind        = RK_MISS;
    dst         = src;
    data        = '0;
    dirty       = 1'b0;
    store_we    = 1'b0;
    store_wdata = DATA_W'(src);
    own_set     = 1'b0;
    own_clr     = 1'b0;
    line_mark   = 1'b0;
    if (req_valid) begin
      unique case (op)
        OP_READ: begin
          rsp_go = 1'b1;
          if (owned) begin
            kind = RK_FWD_READ;
            dst  = owner;
          end else if (lvalid) begin
            kind  = RK_DATA;
            data  = stored;
            dirty = ldirty;
          end else begin
            kind = RK_MISS;
          end
        end
        OP_CLAIM: begin
          rsp_go   = 1'b1;
          store_we = 1'b1;
          own_set  = 1'b1;
          if (!owned) begin
            kind = RK_ACK;
            data = stored;
          end else if (by_owner) begin
            kind = RK_ACK;
          end else begin
            kind = RK_FWD_CLAIM;
            dst  = owner;
          end
        end
        OP_WBACK: begin
          rsp_go = 1'b1;
          if (by_owner) begin
            kind        = RK_WB_DONE;
            store_we    = 1'b1;
            store_wdata = wb_data;
            own_clr     = 1'b1;
            line_mark   = 1'b1;
          end else begin
            kind = RK_WB_STALE;
          end
        end
        default: rsp_go = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/ownr_registry_bank.sv
module ownr_registry_bank
  import ownr_pkg::*;
#(
  parameter int NUM_L1 = 4,
  parameter int LINES = 16,
  parameter int WPL = 4,
  parameter int DATA_W = 32,
  localparam int ID_W = (NUM_L1 > 1) ? $clog2(NUM_L1) : 1,
  localparam int LINE_W = (LINES > 1) ? $clog2(LINES) : 1,
  localparam int WORD_W = (WPL > 1) ? $clog2(WPL) : 1,
  localparam int NW = LINES * WPL,
  localparam int AW = $clog2(NW)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ID_W-1:0]   req_src,
  input  logic [LINE_W-1:0] req_line,
  input  logic [WORD_W-1:0] req_word,
  input  logic [DATA_W-1:0] req_data,
  output logic              rsp_valid,
  output logic [2:0]        rsp_kind,
  output logic [ID_W-1:0]   rsp_dst,
  output logic [ID_W-1:0]   rsp_req,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_dirty
);
  logic [AW-1:0]     widx;
  logic [DATA_W-1:0] stored;
  logic              owned, lvalid, ldirty;
  logic              rsp_go, store_we, own_set, own_clr, line_mark;
  rsp_e              kind;
  logic [ID_W-1:0]   dst;
  logic [DATA_W-1:0] data, store_wdata;
  logic              dirty;

  assign widx = AW'(req_line) * AW'(WPL) + AW'(req_word);

  ownr_word_store #(.DEPTH(NW), .DATA_W(DATA_W)) u_store (
    .clk(clk), .we(store_we), .addr(widx), .wdata(store_wdata), .rdata(stored)
  );

  ownr_meta #(.LINES(LINES), .WPL(WPL)) u_meta (
    .clk(clk), .rst(rst), .widx(widx), .lidx(req_line),
    .own_set(own_set), .own_clr(own_clr), .line_mark(line_mark),
    .owned(owned), .lvalid(lvalid), .ldirty(ldirty)
  );

  ownr_decide #(.ID_W(ID_W), .DATA_W(DATA_W)) u_decide (
    .req_valid(req_valid), .op(op_e'(req_op)), .src(req_src), .wb_data(req_data),
    .owned(owned), .lvalid(lvalid), .ldirty(ldirty), .stored(stored),
    .rsp_go(rsp_go), .kind(kind), .dst(dst), .data(data), .dirty(dirty),
    .store_we(store_we), .store_wdata(store_wdata),
    .own_set(own_set), .own_clr(own_clr), .line_mark(line_mark)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_kind  <= '0;
      rsp_dst   <= '0;
      rsp_req   <= '0;
      rsp_data  <= '0;
      rsp_dirty <= 1'b0;
    end else begin
      rsp_valid <= rsp_go;
      rsp_kind  <= kind;
      rsp_dst   <= dst;
      rsp_req   <= req_src;
      rsp_data  <= data;
      rsp_dirty <= dirty;
    end
  end

  // R2: a response always follows a request one cycle earlier
  p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid));
  // R2: idle cycles never yield a response
  p_idle_silent_r2: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  // R7: a forwarded claim always goes to a cache other than the claimer
  p_fwd_claim_other_r7: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_kind == RK_FWD_CLAIM) |-> (rsp_dst != rsp_req));
  // R3: data answers go back to the cache that asked
  p_data_to_asker_r3: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_kind == RK_DATA) |-> (rsp_dst == $past(req_src)));
  // R2: response kind is always a defined code
  p_kind_legal_r2: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_kind <= 3'd6));
endmodule

// File: tb/tb_ownr_registry_bank.sv
module tb_ownr_registry_bank;
  localparam int CLK_PERIOD = 10;
  localparam int ID_W = 2, LINE_W = 4, WORD_W = 2, DATA_W = 32;
  localparam logic [2:0] K_DATA = 0, K_ACK = 1, K_FR = 2, K_FC = 3,
                         K_MISS = 4, K_WBD = 5, K_WBS = 6;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0;
  logic [1:0] req_op = '0;
  logic [ID_W-1:0] req_src = '0;
  logic [LINE_W-1:0] req_line = '0;
  logic [WORD_W-1:0] req_word = '0;
  logic [DATA_W-1:0] req_data = '0;
  logic rsp_valid, rsp_dirty;
  logic [2:0] rsp_kind;
  logic [ID_W-1:0] rsp_dst, rsp_req;
  logic [DATA_W-1:0] rsp_data;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ownr_registry_bank dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_src(req_src), .req_line(req_line), .req_word(req_word),
    .req_data(req_data), .rsp_valid(rsp_valid), .rsp_kind(rsp_kind),
    .rsp_dst(rsp_dst), .rsp_req(rsp_req), .rsp_data(rsp_data),
    .rsp_dirty(rsp_dirty)
  );

  // Present one request at a negedge; return at the next negedge.
  task automatic send(input logic [1:0] op, input int src, input int line,
                      input int word, input logic [DATA_W-1:0] d);
    req_valid = 1'b1; req_op = op; req_src = ID_W'(src);
    req_line = LINE_W'(line); req_word = WORD_W'(word); req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_rsp(input string tag, input logic [2:0] k, input int d,
                            input int rq, input logic [DATA_W-1:0] dat,
                            input bit cmp_dat, input bit dty);
    n_chk++;
    if (!rsp_valid || rsp_kind != k || rsp_dst != ID_W'(d) || rsp_req != ID_W'(rq)
        || (cmp_dat && rsp_data != dat) || (k == K_DATA && rsp_dirty != dty)) begin
      n_bad++;
      $display("FAIL %s: got v=%0b k=%0d dst=%0d req=%0d data=%h dirty=%0b exp k=%0d dst=%0d req=%0d data=%h dirty=%0b",
               tag, rsp_valid, rsp_kind, rsp_dst, rsp_req, rsp_data, rsp_dirty,
               k, d, rq, dat, dty);
    end
  endtask

  task automatic expect_none(input string tag);
    n_chk++;
    if (rsp_valid) begin
      n_bad++;
      $display("FAIL %s: got rsp_valid=1 exp 0", tag);
    end
  endtask

  task automatic t_reset;
    expect_none("R1 reset quiet");
    send(0, 0, 0, 0, 0);  expect_rsp("R1 R4 miss l0", K_MISS, 0, 0, 0, 0, 0);
    send(0, 3, 15, 3, 0); expect_rsp("R1 R4 miss l15", K_MISS, 3, 3, 0, 0, 0);
  endtask

  task automatic t_silent;
    send(3, 1, 2, 1, 0); expect_none("R2 reserved op");
    @(negedge clk);      expect_none("R2 idle");
  endtask

  task automatic t_claim;
    send(1, 1, 2, 1, 0); expect_rsp("R6 first claim", K_ACK, 1, 1, 0, 0, 0);
    send(0, 2, 2, 1, 0); expect_rsp("R5 fwd read", K_FR, 1, 2, 0, 0, 0);
    send(0, 0, 2, 0, 0); expect_rsp("R12 neighbour free", K_MISS, 0, 0, 0, 0, 0);
  endtask

  task automatic t_steal;
    send(1, 3, 2, 1, 0); expect_rsp("R7 fwd claim", K_FC, 1, 3, 0, 0, 0);
    send(0, 0, 2, 1, 0); expect_rsp("R7 new owner", K_FR, 3, 0, 0, 0, 0);
    send(1, 3, 2, 1, 0); expect_rsp("R8 re-claim", K_ACK, 3, 3, 0, 0, 0);
    send(0, 2, 2, 1, 0); expect_rsp("R8 owner kept", K_FR, 3, 2, 0, 0, 0);
  endtask

  task automatic t_writeback;
    send(2, 1, 2, 1, 32'hDEAD_0001); expect_rsp("R10 stale wb", K_WBS, 1, 1, 0, 0, 0);
    send(0, 0, 2, 1, 0); expect_rsp("R10 still owned", K_FR, 3, 0, 0, 0, 0);
    send(2, 3, 2, 1, 32'h0000_CAFE); expect_rsp("R9 wb done", K_WBD, 3, 3, 0, 0, 0);
    @(negedge clk);
    send(0, 0, 2, 1, 0); expect_rsp("R9 R3 data dirty", K_DATA, 0, 0, 32'h0000_CAFE, 1, 1);
    send(2, 2, 2, 1, 32'hBAD0_BAD0); expect_rsp("R10 wb unowned", K_WBS, 2, 2, 0, 0, 0);
    send(0, 1, 2, 1, 0); expect_rsp("R10 data kept", K_DATA, 1, 1, 32'h0000_CAFE, 1, 1);
    send(1, 0, 2, 1, 0); expect_rsp("R6 ack data", K_ACK, 0, 0, 32'h0000_CAFE, 1, 0);
  endtask

  task automatic t_back_to_back;
    req_valid = 1'b1; req_op = 2'd1; req_src = 2'd0; req_line = 4'd5; req_word = 2'd2;
    @(negedge clk);
    expect_rsp("R11 first ack", K_ACK, 0, 0, 0, 0, 0);
    req_src = 2'd2;
    @(negedge clk);
    expect_rsp("R11 second fwd", K_FC, 0, 2, 0, 0, 0);
    req_op = 2'd2; req_data = 32'h1234_5678;
    @(negedge clk);
    expect_rsp("R11 wb done", K_WBD, 2, 2, 0, 0, 0);
    req_op = 2'd0; req_src = 2'd1;
    @(negedge clk);
    expect_rsp("R11 read after wb", K_DATA, 1, 1, 32'h1234_5678, 1, 1);
    req_valid = 1'b0;
    @(negedge clk);
    expect_none("R2 after burst");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_silent();
    t_claim();
    t_steal();
    t_writeback();
    t_back_to_back();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not end, got timeout exp completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule